// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block joins two processors, called side A and side B, through four word-wide message lanes in each direction and four doorbells in each direction. A word written into one of a side's four transmit slots becomes visible in the matching receive slot of the opposite side. A per-slot flag pair on each side (transmit-empty for the sender, receive-full for the reader) gives a one-word handshake. Messages longer than one word are spread over the four lanes in turn: word i uses lane i mod 4, and the sender waits for that lane's empty flag before reusing it.

Each side also has a doorbell path. Setting a request bit in one side's control word raises the matching pending flag on the far side. The far side acknowledges by writing one to that flag. Each side drives its own interrupt line. The line is the OR of every status condition whose enable bit is set in that side's control word.

Both register ports are simple single-cycle accesses: a select, a write strobe, a word index, and write data. Read data is returned in the same cycle as the access. The side effects of a read (such as draining a lane) take place on the clock edge that ends the access.

Top module: `mu_pair`

## Requirements
- R1: After reset, both sides read status 0x00F00000 (all transmit-empty flags set, no receive-full or pending flags), both control words read 0, and both interrupt lines are low.
- R2: A write to transmit slot n (word index n, 0..3) on either side, while that lane is empty, stores the word. From the next cycle the writer's transmit-empty flag n is 0, the peer's receive-full flag n is 1, and the peer reads the word at receive slot n (word index 4+n).
- R3: A read of receive slot n while it is full clears that side's receive-full flag n and sets the sender's transmit-empty flag n from the next cycle.
- R4: A write to a transmit slot whose lane is still full is dropped. The peer later reads the earlier word.
- R5: Word index 8 is status and 9 is control. Transmit slots read as 0. Writes to receive slots and to unmapped indices change no state.
- R6: In status, transmit-empty n is bit 20+(3-n), receive-full n is bit 24+(3-n), and pending n is bit 28+(3-n). All other bits read 0.
- R7: In control, the transmit, receive and doorbell interrupt enables for index n are bits 20+(3-n), 24+(3-n) and 28+(3-n). Doorbell request n is bit 16+(3-n). A request bit clears by itself once the far pending flag has been set, and reads 0 by the second cycle after the write.
- R8: A doorbell request n on one side sets pending flag n on the far side on the clock edge after the request bit is written.
- R9: Writing one to a pending bit in status clears it. Writing zero leaves it unchanged.
- R10: Each side's interrupt is high exactly when some status flag is set and its enable bit is also set. With all enables clear the line stays low.
- R11: An eight-word message sent as words 0..7 over lanes i mod 4 reaches the reader in order when both ends follow the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 4 | Side A word index |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid during a read access |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 4 | Side B word index |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid during a read access |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions watch the A-to-B lanes on every cycle. They check that a write to an empty lane fills it with the written word, that a write to a full lane leaves the held word untouched, and that a read drains the lane. They also check that a doorbell request is pending on the far side one edge later, that the request bit drops by itself, and that side A's interrupt stays low while none of its enables are set. The bit positions in the status and control words, the decode of unmapped and read-only slots, the write-one-to-clear acknowledge, and the in-order delivery of a round-robin message are shown only through the bench's directed scenarios, which read everything back through the register ports.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned NREG      = 4;
  localparam int unsigned DW        = 32;
  localparam int unsigned SW        = 4;
  localparam int unsigned HW        = 16;
  localparam int unsigned SLOT_RX0  = 4;
  localparam int unsigned SLOT_STAT = 8;
  localparam int unsigned SLOT_CTRL = 9;
  localparam int unsigned GIR_BASE  = 16;
  localparam int unsigned TE_BASE   = 20;
  localparam int unsigned RF_BASE   = 24;
  localparam int unsigned GP_BASE   = 28;
endpackage

// File: rtl/mu_reset_sync.sv
module mu_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/mu_lane.sv
module mu_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          full
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q;
  logic          accept;

  always_comb begin
    accept = wr_en & ~full_q;
    full_d = full_q;
    if (accept)     full_d = 1'b1;
    else if (rd_en) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) data_q <= wdata;
    end
  end

  assign data = data_q;
  assign full = full_q;
endmodule

// File: rtl/mu_side.sv
module mu_side
  import mu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    wr,
  input  logic [SW-1:0]           slot,
  input  logic [HW-1:0]           hi_wdata,
  input  logic [NREG-1:0]         tx_full,
  input  logic [NREG-1:0]         rx_full,
  input  logic [NREG-1:0][DW-1:0] rx_data,
  input  logic [NREG-1:0]         peer_gir,
  output logic [NREG-1:0]         tx_wr,
  output logic [NREG-1:0]         rx_rd,
  output logic [NREG-1:0]         gir,
  output logic [DW-1:0]           rdata,
  output logic                    irq
);
  logic [NREG-1:0] tie_q, rie_q, gie_q, gir_q, gip_q;
  logic [NREG-1:0] tie_w, rie_w, gie_w, gir_w, gp_w;
  logic [NREG-1:0] gir_d, gip_d;
  logic            wr_ctrl, wr_stat, rd_any;
  logic [DW-1:0]   stat_word, ctrl_word;

  always_comb begin
    wr_ctrl = sel & wr & (slot == SW'(SLOT_CTRL));
    wr_stat = sel & wr & (slot == SW'(SLOT_STAT));
    rd_any  = sel & ~wr;
    for (int n = 0; n < NREG; n++) begin
      tx_wr[n] = sel & wr & (slot == SW'(n));
      rx_rd[n] = rd_any & (slot == SW'(SLOT_RX0 + n));
      gir_w[n] = hi_wdata[GIR_BASE - HW + NREG - 1 - n];
      tie_w[n] = hi_wdata[TE_BASE  - HW + NREG - 1 - n];
      rie_w[n] = hi_wdata[RF_BASE  - HW + NREG - 1 - n];
      gie_w[n] = hi_wdata[GP_BASE  - HW + NREG - 1 - n];
      gp_w[n]  = hi_wdata[GP_BASE  - HW + NREG - 1 - n];
    end
    gir_d = wr_ctrl ? gir_w : '0;
    gip_d = (gip_q & ~(wr_stat ? gp_w : '0)) | peer_gir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie_q <= '0;
      rie_q <= '0;
      gie_q <= '0;
      gir_q <= '0;
      gip_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tie_q <= tie_w;
        rie_q <= rie_w;
        gie_q <= gie_w;
      end
      gir_q <= gir_d;
      gip_q <= gip_d;
    end
  end

  always_comb begin
    stat_word = '0;
    ctrl_word = '0;
    for (int n = 0; n < NREG; n++) begin
      stat_word[TE_BASE  + NREG - 1 - n] = ~tx_full[n];
      stat_word[RF_BASE  + NREG - 1 - n] = rx_full[n];
      stat_word[GP_BASE  + NREG - 1 - n] = gip_q[n];
      ctrl_word[GIR_BASE + NREG - 1 - n] = gir_q[n];
      ctrl_word[TE_BASE  + NREG - 1 - n] = tie_q[n];
      ctrl_word[RF_BASE  + NREG - 1 - n] = rie_q[n];
      ctrl_word[GP_BASE  + NREG - 1 - n] = gie_q[n];
    end
    rdata = '0;
    if (rd_any) begin
      if (slot == SW'(SLOT_STAT)) rdata = stat_word;
      if (slot == SW'(SLOT_CTRL)) rdata = ctrl_word;
      for (int n = 0; n < NREG; n++)
        if (slot == SW'(SLOT_RX0 + n)) rdata = rx_data[n];
    end
  end

  assign irq = (|(~tx_full & tie_q)) | (|(rx_full & rie_q)) | (|(gip_q & gie_q));
  assign gir = gir_q;
endmodule

// File: rtl/mu_pair.sv
module mu_pair
  import mu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [SW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [SW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  logic                    rst_q_n;
  logic [NREG-1:0]         ab_full, ba_full;
  logic [NREG-1:0][DW-1:0] ab_data, ba_data;
  logic [NREG-1:0]         a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NREG-1:0]         a_gir, b_gir;

  mu_reset_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar n = 0; n < NREG; n++) begin : g_lane
    mu_lane #(.DW(DW)) u_ab (
      .clk   (clk),
      .rst_n (rst_q_n),
      .wr_en (a_tx_wr[n]),
      .rd_en (b_rx_rd[n]),
      .wdata (a_wdata),
      .data  (ab_data[n]),
      .full  (ab_full[n])
    );
    mu_lane #(.DW(DW)) u_ba (
      .clk   (clk),
      .rst_n (rst_q_n),
      .wr_en (b_tx_wr[n]),
      .rd_en (a_rx_rd[n]),
      .wdata (b_wdata),
      .data  (ba_data[n]),
      .full  (ba_full[n])
    );
  end

  mu_side u_side_a (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sel      (a_sel),
    .wr       (a_wr),
    .slot     (a_addr),
    .hi_wdata (a_wdata[DW-1:DW-HW]),
    .tx_full  (ab_full),
    .rx_full  (ba_full),
    .rx_data  (ba_data),
    .peer_gir (b_gir),
    .tx_wr    (a_tx_wr),
    .rx_rd    (a_rx_rd),
    .gir      (a_gir),
    .rdata    (a_rdata),
    .irq      (a_irq)
  );

  mu_side u_side_b (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .sel      (b_sel),
    .wr       (b_wr),
    .slot     (b_addr),
    .hi_wdata (b_wdata[DW-1:DW-HW]),
    .tx_full  (ba_full),
    .rx_full  (ab_full),
    .rx_data  (ab_data),
    .peer_gir (a_gir),
    .tx_wr    (b_tx_wr),
    .rx_rd    (b_rx_rd),
    .gir      (b_gir),
    .rdata    (b_rdata),
    .irq      (b_irq)
  );
endmodule

// File: rtl/mu_pair_chk.sv
module mu_pair_chk
  import mu_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    a_sel,
  input logic                    a_wr,
  input logic [SW-1:0]           a_addr,
  input logic [DW-1:0]           a_wdata,
  input logic                    b_sel,
  input logic                    b_wr,
  input logic [SW-1:0]           b_addr,
  input logic [NREG-1:0]         ab_full,
  input logic [NREG-1:0][DW-1:0] ab_data,
  input logic [NREG-1:0]         a_gir,
  input logic [NREG-1:0]         b_gip,
  input logic                    a_en_none,
  input logic                    a_irq
);
  for (genvar n = 0; n < NREG; n++) begin : g_n
    // R2
    fill_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_sel && a_wr && a_addr == SW'(n) && !ab_full[n])
        |=> (ab_full[n] && ab_data[n] == $past(a_wdata)));

    // R4
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_sel && a_wr && a_addr == SW'(n) && ab_full[n])
        |=> (ab_data[n] == $past(ab_data[n])));

    // R3
    drain_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_sel && !b_wr && b_addr == SW'(SLOT_RX0 + n) && ab_full[n])
        |=> !ab_full[n]);

    // R8
    bell_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_gir[n] |=> b_gip[n]);

    // R7
    bell_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_gir[n] && !(a_sel && a_wr && a_addr == SW'(SLOT_CTRL))) |=> !a_gir[n]);
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_en_none |-> !a_irq);
endmodule

bind mu_pair mu_pair_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .a_sel     (a_sel),
  .a_wr      (a_wr),
  .a_addr    (a_addr),
  .a_wdata   (a_wdata),
  .b_sel     (b_sel),
  .b_wr      (b_wr),
  .b_addr    (b_addr),
  .ab_full   (ab_full),
  .ab_data   (ab_data),
  .a_gir     (a_gir),
  .b_gip     (u_side_b.gip_q),
  .a_en_none (~|{u_side_a.tie_q, u_side_a.rie_q, u_side_a.gie_q}),
  .a_irq     (a_irq)
);

// File: tb/mu_pair_tb_top.sv
`timescale 1ns/1ps
module mu_pair_tb_top;
  logic        clk;
  logic        rst_n;
  logic        a_sel, a_wr, b_sel, b_wr;
  logic [3:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks;
  int fails;
  bit done;

  localparam logic [3:0] ST = 4'd8;
  localparam logic [3:0] CT = 4'd9;
  localparam logic [31:0] IDLE_ST = 32'h00F0_0000;

  mu_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // one access on side sd (0=A, 1=B)
  task automatic acc(input bit sd, input bit w, input logic [3:0] ad,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    if (!sd) begin a_sel = 1; a_wr = w; a_addr = ad; a_wdata = wd; end
    else     begin b_sel = 1; b_wr = w; b_addr = ad; b_wdata = wd; end
    #1 rd = sd ? b_rdata : a_rdata;
    @(posedge clk);
    #1;
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic wr(input bit sd, input logic [3:0] ad, input logic [31:0] wd);
    logic [31:0] dummy;
    acc(sd, 1'b1, ad, wd, dummy);
  endtask

  task automatic rd(input bit sd, input logic [3:0] ad, output logic [31:0] v);
    acc(sd, 1'b0, ad, 32'h0, v);
  endtask

  task automatic wait_bit(input bit sd, input int pos, input string tag);
    logic [31:0] v;
    int tries;
    tries = 0;
    do begin
      rd(sd, ST, v);
      tries++;
    end while (!v[pos] && tries < 40);
    chk(tag, {31'h0, v[pos]}, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, ST, v); chk("R1 A status", v, IDLE_ST);
    rd(1, ST, v); chk("R1 B status", v, IDLE_ST);
    rd(0, CT, v); chk("R1 A control", v, 32'h0);
    rd(1, CT, v); chk("R1 B control", v, 32'h0);
    chk("R1 irqs", {30'h0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(0, 4'd2, 32'hDEAD_BEEF);
    rd(0, ST, v); chk("R2 R6 A TE2 clear", v, 32'h00D0_0000);
    rd(1, ST, v); chk("R2 R6 B RF2 set", v, 32'h02F0_0000);
    rd(1, 4'd6, v); chk("R2 B rx2 data", v, 32'hDEAD_BEEF);
    rd(1, ST, v); chk("R3 B RF2 cleared", v, IDLE_ST);
    rd(0, ST, v); chk("R3 A TE2 restored", v, IDLE_ST);
    wr(1, 4'd3, 32'h1234_5678);
    rd(1, ST, v); chk("R2 R6 B TE3 clear", v, 32'h00E0_0000);
    rd(0, ST, v); chk("R2 R6 A RF3 set", v, 32'h01F0_0000);
    rd(0, 4'd7, v); chk("R2 A rx3 data", v, 32'h1234_5678);
    rd(1, ST, v); chk("R3 B TE3 restored", v, IDLE_ST);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(0, 4'd0, 32'h0000_0011);
    wr(0, 4'd0, 32'h0000_0022);
    rd(1, 4'd4, v); chk("R4 dropped write keeps first word", v, 32'h0000_0011);
    rd(1, ST, v); chk("R4 lane empty after one read", v, IDLE_ST);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    wr(0, 4'd0, 32'hCAFE_0001);
    rd(0, 4'd0, v); chk("R5 tx slot reads zero", v, 32'h0);
    rd(1, 4'd4, v); chk("R5 flush", v, 32'hCAFE_0001);
    wr(0, 4'd5, 32'hFFFF_FFFF);
    rd(0, ST, v); chk("R5 rx write ignored A", v, IDLE_ST);
    rd(1, ST, v); chk("R5 rx write ignored B", v, IDLE_ST);
    wr(0, 4'd10, 32'hFFFF_FFFF);
    rd(0, CT, v); chk("R5 unmapped write ignored", v, 32'h0);
    chk("R5 no irq", {31'h0, a_irq}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, CT, 32'h0800_0000);
    rd(1, CT, v); chk("R7 RIE0 position", v, 32'h0800_0000);
    chk("R10 no irq while empty", {31'h0, b_irq}, 32'h0);
    wr(0, 4'd0, 32'h0000_0055);
    chk("R10 rx irq raised", {31'h0, b_irq}, 32'h1);
    rd(1, 4'd4, v);
    chk("R10 rx irq drops", {31'h0, b_irq}, 32'h0);
    wr(1, CT, 32'h0);
    wr(0, CT, 32'h0010_0000);
    chk("R10 R7 TIE3 with TE3 set", {31'h0, a_irq}, 32'h1);
    wr(0, CT, 32'h0);
    chk("R10 irq off", {31'h0, a_irq}, 32'h0);
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    wr(0, CT, 32'h0004_0000);
    @(posedge clk); #1;
    rd(0, CT, v); chk("R7 request self-clears", v, 32'h0);
    rd(1, ST, v); chk("R8 R6 B pending1", v, 32'h40F0_0000);
    rd(0, ST, v); chk("R8 A unaffected", v, IDLE_ST);
    wr(1, CT, 32'h4000_0000);
    chk("R10 doorbell irq", {31'h0, b_irq}, 32'h1);
    wr(1, ST, 32'h0);
    rd(1, ST, v); chk("R9 zero write keeps pending", v, 32'h40F0_0000);
    wr(1, ST, 32'h4000_0000);
    rd(1, ST, v); chk("R9 w1c clears pending", v, IDLE_ST);
    chk("R9 irq drops", {31'h0, b_irq}, 32'h0);
    wr(1, CT, 32'h0);
  endtask

  task automatic t_roundrobin();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(0, 4'(i), 32'hA500_0000 + i);
    for (int i = 4; i < 8; i++) begin
      wait_bit(1, 24 + 3 - ((i - 4) % 4), "R11 RF ready");
      rd(1, 4'(4 + (i - 4) % 4), v); chk("R11 word order", v, 32'hA500_0000 + (i - 4));
      wait_bit(0, 20 + 3 - (i % 4), "R11 TE ready");
      wr(0, 4'(i % 4), 32'hA500_0000 + i);
    end
    for (int i = 4; i < 8; i++) begin
      wait_bit(1, 24 + 3 - (i % 4), "R11 RF ready");
      rd(1, 4'(4 + i % 4), v); chk("R11 word order", v, 32'hA500_0000 + i);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    a_sel = 0; a_wr = 0; a_addr = 0; a_wdata = 0;
    b_sel = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_single();
    t_overflow();
    t_decode();
    t_irq();
    t_doorbell();
    t_roundrobin();
    done = 1;
    summary();
    $finish;
  end
endmodule